// File: doc/BRIEF.md
# Indirect Register Configuration Master for an 8-bit Microport

This block sits on the host side of an 8-bit, non-multiplexed, strobe-based microport (chip select, read and write strobes, a 3-bit external address, an 8-bit data bus and a ready return line). After a start pulse, it walks a configuration list fixed at elaboration time and turns each list entry into one or more microport write cycles. The peripheral's internal registers are reached indirectly. The internal address goes into the channel-address register at external address 6. The data bytes go into the data registers at external addresses 2, 1 and 0. The write to address 0 launches the internal transfer, so it always comes last. External address 3 is the sleep register, and its bit 5 selects the register page (1 = output-port page, 0 = channel page). The master keeps a copy of the last sleep value it wrote and rewrites that register only when an entry needs the other page.

Each access first drives chip select with a steady address and data. It then drops the write strobe for a minimum number of wait states. That minimum is the ceiling of the system-to-peripheral clock ratio plus two synchronizer cycles, capped at 15. After that, the strobe stays low until the ready line, seen through a two-flop synchronizer, is high. If ready does not return within a timeout window, the master releases the strobes, stops the list and flags an error.

Top module: `cfg_uport_master`

## Requirements
- R1: During and right after reset, `uport_cs_no`, `uport_wr_no` and `uport_rd_no` are 1, and `busy_o`, `done_o` and `err_o` are 0. `uport_rd_no` stays 1 at all times.
- R2: A list entry is a 36-bit packed word {indirect[35], page[34], nbytes[33:32], iaddr[31:24], data[23:0]}. A direct entry (indirect = 0) makes one write to external address iaddr[2:0] with data[7:0].
- R3: An indirect entry writes external address 6 with iaddr. It then writes address 2 with data[23:16] if nbytes = 3, then address 1 with data[15:8] if nbytes >= 2, and finally address 0 with data[7:0]. An nbytes value of 0 or 1 writes address 0 only.
- R4: Before the address-6 write of an indirect entry, if bit 5 of the last value written to address 3 differs from the entry's page bit, one write to address 3 is inserted. Its data is that last value with bit 5 replaced by the page bit. The last value is 0x00 after reset.
- R5: The write strobe stays low for at least WAIT_STATES clock cycles, where WAIT_STATES = min(ceil(SYS_CLK_KHZ / PER_CLK_KHZ) + 2, 15). With the default parameters this is 5.
- R6: A write completes only after ready has passed through the two-flop synchronizer. At least two full clock cycles pass between ready rising and the write strobe rising, and a strobe release is always backed by ready being high three clock edges before the release is observed.
- R7: The write strobe is low only while chip select is low. Address and data stay stable for as long as chip select stays low.
- R8: If ready is not seen high within TIMEOUT (default 64) cycles of strobe-low time, the strobe is released after exactly TIMEOUT cycles. Then `err_o` and `done_o` go to 1, `busy_o` goes to 0, and no later list write is made.
- R9: `start_i` is ignored while `busy_o` is 1. Outside that time, a start runs the list from its first entry and clears `done_o` and `err_o`.
- R10: After the last list write completes, `busy_o` is 0, `done_o` is 1, `err_o` is 0 and chip select stays high. `busy_o` and `done_o` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Pulse to run the configuration list |
| uport_rdy_i | input | 1 | Peripheral ready, asynchronous, low while an access is in progress |
| uport_a_o | output | 3 | External register address |
| uport_d_o | output | 8 | Write data |
| uport_cs_no | output | 1 | Chip select, active low |
| uport_wr_no | output | 1 | Write strobe, active low |
| uport_rd_no | output | 1 | Read strobe, active low, held inactive |
| busy_o | output | 1 | List in progress |
| done_o | output | 1 | List finished or aborted |
| err_o | output | 1 | Ready timeout caused the abort |

## Verification
The assertions check on every cycle the strobe nesting inside chip select, the stability of address and data while chip select is low, the minimum and maximum strobe-low lengths, and the fact that every normal strobe release is backed by ready three edges earlier. They also check that busy and done are exclusive and that an error is always reported with done. Only the bench scenarios can show the order and content of the writes an entry expands into. They also cover the page-switch insertion and its dependence on earlier sleep writes across runs, the abort point of a timed-out list, a start that arrives mid-run and is ignored, and a clean rerun after an error.

// File: rtl/cfg_uport_pkg.sv
package cfg_uport_pkg;

  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 8;
  localparam int PAGE_BIT = 5;

  localparam logic [ADDR_W-1:0] EXT_DR0   = 3'd0;
  localparam logic [ADDR_W-1:0] EXT_DR1   = 3'd1;
  localparam logic [ADDR_W-1:0] EXT_DR2   = 3'd2;
  localparam logic [ADDR_W-1:0] EXT_SLEEP = 3'd3;
  localparam logic [ADDR_W-1:0] EXT_CAR   = 3'd6;
  localparam logic [ADDR_W-1:0] EXT_ACR   = 3'd7;

  typedef struct packed {
    logic        indirect;
    logic        page;
    logic [1:0]  nbytes;
    logic [7:0]  iaddr;
    logic [23:0] data;
  } entry_t;

  typedef enum logic [2:0] {
    STEP_NEW,
    STEP_CAR,
    STEP_D2,
    STEP_D1,
    STEP_D0
  } step_e;

  localparam entry_t DEFAULT_LIST [5] = '{
    '{indirect: 1'b0, page: 1'b0, nbytes: 2'd0, iaddr: 8'h07, data: 24'h000000},
    '{indirect: 1'b0, page: 1'b0, nbytes: 2'd0, iaddr: 8'h03, data: 24'h00002F},
    '{indirect: 1'b1, page: 1'b1, nbytes: 2'd3, iaddr: 8'h1E, data: 24'h000001},
    '{indirect: 1'b1, page: 1'b1, nbytes: 2'd1, iaddr: 8'h1B, data: 24'h000000},
    '{indirect: 1'b1, page: 1'b1, nbytes: 2'd1, iaddr: 8'h1A, data: 24'h000000}
  };

endpackage

// File: rtl/cfg_uport_sync.sv
module cfg_uport_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= {STAGES{RST_VAL}};
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/cfg_uport_expand.sv
module cfg_uport_expand import cfg_uport_pkg::*; (
  input  entry_t            entry_i,
  input  step_e             step_i,
  input  logic [DATA_W-1:0] sleep_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              last_o,
  output step_e             step_nxt_o
);

  step_e first_dat;

  always_comb begin
    if (entry_i.nbytes == 2'd3)      first_dat = STEP_D2;
    else if (entry_i.nbytes == 2'd2) first_dat = STEP_D1;
    else                             first_dat = STEP_D0;
  end

  always_comb begin
    addr_o     = EXT_DR0;
    data_o     = '0;
    last_o     = 1'b0;
    step_nxt_o = STEP_NEW;
    if (!entry_i.indirect) begin
      addr_o = entry_i.iaddr[ADDR_W-1:0];
      data_o = entry_i.data[DATA_W-1:0];
      last_o = 1'b1;
    end else begin
      unique case (step_i)
        STEP_NEW: begin
          if (sleep_i[PAGE_BIT] != entry_i.page) begin
            addr_o           = EXT_SLEEP;
            data_o           = sleep_i;
            data_o[PAGE_BIT] = entry_i.page;
            step_nxt_o       = STEP_CAR;
          end else begin
            addr_o     = EXT_CAR;
            data_o     = entry_i.iaddr;
            step_nxt_o = first_dat;
          end
        end
        STEP_CAR: begin
          addr_o     = EXT_CAR;
          data_o     = entry_i.iaddr;
          step_nxt_o = first_dat;
        end
        STEP_D2: begin
          addr_o     = EXT_DR2;
          data_o     = entry_i.data[23:16];
          step_nxt_o = STEP_D1;
        end
        STEP_D1: begin
          addr_o     = EXT_DR1;
          data_o     = entry_i.data[15:8];
          step_nxt_o = STEP_D0;
        end
        default: begin
          addr_o = EXT_DR0;
          data_o = entry_i.data[7:0];
          last_o = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/cfg_uport_access.sv
module cfg_uport_access import cfg_uport_pkg::*; #(
  parameter int WAIT_STATES = 5,
  parameter int TIMEOUT     = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              rdy_s_i,
  output logic [ADDR_W-1:0] a_o,
  output logic [DATA_W-1:0] d_o,
  output logic              cs_no,
  output logic              wr_no,
  output logic              ack_o,
  output logic              abort_o,
  output logic              fail_o
);

  localparam int CNT_W = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] WS_LAST = CNT_W'(WAIT_STATES - 1);
  localparam logic [CNT_W-1:0] TO_LAST = CNT_W'(TIMEOUT - 1);

  typedef enum logic [1:0] {A_IDLE, A_SETUP, A_STRB, A_HOLD} acc_e;

  acc_e             st_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= A_IDLE;
      a_o     <= '0;
      d_o     <= '0;
      cs_no   <= 1'b1;
      wr_no   <= 1'b1;
      cnt_q   <= '0;
      ack_o   <= 1'b0;
      abort_o <= 1'b0;
      fail_o  <= 1'b0;
    end else begin
      ack_o   <= 1'b0;
      abort_o <= 1'b0;
      unique case (st_q)
        A_IDLE: if (req_i) begin
          a_o   <= addr_i;
          d_o   <= data_i;
          cs_no <= 1'b0;
          st_q  <= A_SETUP;
        end
        A_SETUP: begin
          wr_no <= 1'b0;
          cnt_q <= '0;
          st_q  <= A_STRB;
        end
        A_STRB: begin
          if (cnt_q >= WS_LAST && rdy_s_i) begin
            wr_no  <= 1'b1;
            cs_no  <= 1'b1;
            fail_o <= 1'b0;
            st_q   <= A_HOLD;
          end else if (cnt_q == TO_LAST) begin
            wr_no  <= 1'b1;
            cs_no  <= 1'b1;
            fail_o <= 1'b1;
            st_q   <= A_HOLD;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          ack_o   <= 1'b1;
          abort_o <= fail_o;
          st_q    <= A_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/cfg_uport_master.sv
module cfg_uport_master import cfg_uport_pkg::*; #(
  parameter int          SYS_CLK_KHZ = 133000,
  parameter int          PER_CLK_KHZ = 61440,
  parameter int          SYNC_STAGES = 2,
  parameter int          MAX_WAIT    = 15,
  parameter int          TIMEOUT     = 64,
  parameter logic [7:0]  SLEEP_INIT  = 8'h00,
  parameter int          N_ENTRIES   = 5,
  parameter entry_t      LIST [N_ENTRIES] = DEFAULT_LIST
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              uport_rdy_i,
  output logic [ADDR_W-1:0] uport_a_o,
  output logic [DATA_W-1:0] uport_d_o,
  output logic              uport_cs_no,
  output logic              uport_wr_no,
  output logic              uport_rd_no,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);

  localparam int WS_RAW      = (SYS_CLK_KHZ + PER_CLK_KHZ - 1) / PER_CLK_KHZ + SYNC_STAGES;
  localparam int WAIT_STATES = (WS_RAW > MAX_WAIT) ? MAX_WAIT : WS_RAW;
  localparam int IDX_W       = $clog2(N_ENTRIES + 1);

  typedef enum logic [1:0] {W_IDLE, W_ISSUE, W_WAIT} walk_e;

  walk_e             wst_q;
  logic [IDX_W-1:0]  idx_q;
  step_e             step_q, cur_nxt_q;
  logic              cur_last_q;
  logic [DATA_W-1:0] sleep_q;
  logic              req_q;
  logic [ADDR_W-1:0] req_a_q;
  logic [DATA_W-1:0] req_d_q;

  entry_t            cur_entry;
  logic [ADDR_W-1:0] x_addr;
  logic [DATA_W-1:0] x_data;
  logic              x_last;
  step_e             x_nxt;
  logic              rdy_s;
  logic              acc_ack, acc_abort, acc_fail;

  assign uport_rd_no = 1'b1;

  always_comb begin
    cur_entry = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (idx_q == IDX_W'(i)) cur_entry = LIST[i];
    end
  end

  cfg_uport_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (uport_rdy_i),
    .q_o   (rdy_s)
  );

  cfg_uport_expand u_expand (
    .entry_i   (cur_entry),
    .step_i    (step_q),
    .sleep_i   (sleep_q),
    .addr_o    (x_addr),
    .data_o    (x_data),
    .last_o    (x_last),
    .step_nxt_o(x_nxt)
  );

  cfg_uport_access #(.WAIT_STATES(WAIT_STATES), .TIMEOUT(TIMEOUT)) u_access (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_q),
    .addr_i (req_a_q),
    .data_i (req_d_q),
    .rdy_s_i(rdy_s),
    .a_o    (uport_a_o),
    .d_o    (uport_d_o),
    .cs_no  (uport_cs_no),
    .wr_no  (uport_wr_no),
    .ack_o  (acc_ack),
    .abort_o(acc_abort),
    .fail_o (acc_fail)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wst_q      <= W_IDLE;
      idx_q      <= '0;
      step_q     <= STEP_NEW;
      cur_nxt_q  <= STEP_NEW;
      cur_last_q <= 1'b0;
      sleep_q    <= SLEEP_INIT;
      req_q      <= 1'b0;
      req_a_q    <= '0;
      req_d_q    <= '0;
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      req_q <= 1'b0;
      unique case (wst_q)
        W_IDLE: if (start_i) begin
          idx_q  <= '0;
          step_q <= STEP_NEW;
          busy_o <= 1'b1;
          done_o <= 1'b0;
          err_o  <= 1'b0;
          wst_q  <= W_ISSUE;
        end
        W_ISSUE: begin
          if (idx_q == IDX_W'(N_ENTRIES)) begin
            busy_o <= 1'b0;
            done_o <= 1'b1;
            wst_q  <= W_IDLE;
          end else begin
            req_q      <= 1'b1;
            req_a_q    <= x_addr;
            req_d_q    <= x_data;
            cur_last_q <= x_last;
            cur_nxt_q  <= x_nxt;
            wst_q      <= W_WAIT;
          end
        end
        default: if (acc_ack) begin
          if (acc_abort) begin
            busy_o <= 1'b0;
            done_o <= 1'b1;
            err_o  <= 1'b1;
            wst_q  <= W_IDLE;
          end else begin
            if (req_a_q == EXT_SLEEP) sleep_q <= req_d_q;
            if (cur_last_q) begin
              idx_q  <= idx_q + 1'b1;
              step_q <= STEP_NEW;
            end else begin
              step_q <= cur_nxt_q;
            end
            wst_q <= W_ISSUE;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/cfg_uport_chk.sv
module cfg_uport_chk #(
  parameter int WAIT_STATES = 5,
  parameter int TIMEOUT     = 64
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rdy_i,
  input logic [2:0] a_i,
  input logic [7:0] d_i,
  input logic       cs_ni,
  input logic       wr_ni,
  input logic       fail_i,
  input logic       busy_i,
  input logic       done_i,
  input logic       err_i
);

  logic [15:0] low_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     low_cnt_q <= '0;
    else if (!wr_ni) low_cnt_q <= (low_cnt_q == 16'hFFFF) ? low_cnt_q : low_cnt_q + 16'd1;
    else             low_cnt_q <= '0;
  end

  p_wr_in_cs_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ni |-> !cs_ni);

  p_bus_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && $past(!cs_ni)) |-> ($stable(a_i) && $stable(d_i)));

  p_min_strobe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_ni) |-> (low_cnt_q >= 16'(WAIT_STATES)));

  p_timeout_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ni |-> (low_cnt_q < 16'(TIMEOUT)));

  p_ready_synced_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(wr_ni) && !fail_i) |-> $past(rdy_i, 3));

  p_busy_done_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_i && done_i));

  p_err_with_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |-> done_i);

endmodule

bind cfg_uport_master cfg_uport_chk #(.WAIT_STATES(WAIT_STATES), .TIMEOUT(TIMEOUT)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .rdy_i (uport_rdy_i),
  .a_i   (uport_a_o),
  .d_i   (uport_d_o),
  .cs_ni (uport_cs_no),
  .wr_ni (uport_wr_no),
  .fail_i(acc_fail),
  .busy_i(busy_o),
  .done_i(done_o),
  .err_i (err_o)
);

// File: tb/cfg_uport_master_tb_top.sv
module cfg_uport_master_tb_top;
  import cfg_uport_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int WS_EXP     = 5;
  localparam int TO_EXP     = 64;
  localparam int N_TB       = 7;

  localparam entry_t LIST_TB [N_TB] = '{
    '{indirect: 1'b0, page: 1'b0, nbytes: 2'd0, iaddr: 8'h07, data: 24'h000000},
    '{indirect: 1'b0, page: 1'b0, nbytes: 2'd0, iaddr: 8'h03, data: 24'h00002F},
    '{indirect: 1'b1, page: 1'b1, nbytes: 2'd3, iaddr: 8'h1E, data: 24'hA51C01},
    '{indirect: 1'b1, page: 1'b1, nbytes: 2'd1, iaddr: 8'h1B, data: 24'h000077},
    '{indirect: 1'b1, page: 1'b0, nbytes: 2'd2, iaddr: 8'hA9, data: 24'h003540},
    '{indirect: 1'b1, page: 1'b0, nbytes: 2'd0, iaddr: 8'h10, data: 24'h00005A},
    '{indirect: 1'b0, page: 1'b1, nbytes: 2'd2, iaddr: 8'h05, data: 24'h0000C3}
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start = 1'b0;
  logic       rdy = 1'b1;
  logic [2:0] a;
  logic [7:0] d;
  logic       cs_n, wr_n, rd_n, busy, done, err;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  logic [2:0] exp_a [64];
  logic [7:0] exp_d [64];
  int         n_exp;
  logic [7:0] bench_sh = 8'h00;

  int  widx, stuck_idx, lat_cnt, low_cnt, rel_cnt;
  bit  in_acc, stuck_now, had_low;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cfg_uport_master #(.N_ENTRIES(N_TB), .LIST(LIST_TB)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .uport_rdy_i(rdy),
    .uport_a_o  (a),
    .uport_d_o  (d),
    .uport_cs_no(cs_n),
    .uport_wr_no(wr_n),
    .uport_rd_no(rd_n),
    .busy_o     (busy),
    .done_o     (done),
    .err_o      (err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic add_exp(input logic [2:0] ea, input logic [7:0] ed);
    exp_a[n_exp] = ea;
    exp_d[n_exp] = ed;
    n_exp++;
  endtask

  // expected write stream from R2, R3, R4
  task automatic build_exp(input logic [7:0] sh_in);
    logic [7:0] sh, v;
    sh = sh_in;
    n_exp = 0;
    for (int i = 0; i < N_TB; i++) begin
      if (!LIST_TB[i].indirect) begin
        add_exp(LIST_TB[i].iaddr[2:0], LIST_TB[i].data[7:0]);
        if (LIST_TB[i].iaddr[2:0] == 3'd3) sh = LIST_TB[i].data[7:0];
      end else begin
        if (sh[5] != LIST_TB[i].page) begin
          v = sh;
          v[5] = LIST_TB[i].page;
          add_exp(3'd3, v);
          sh = v;
        end
        add_exp(3'd6, LIST_TB[i].iaddr);
        if (LIST_TB[i].nbytes == 2'd3) add_exp(3'd2, LIST_TB[i].data[23:16]);
        if (LIST_TB[i].nbytes >= 2'd2) add_exp(3'd1, LIST_TB[i].data[15:8]);
        add_exp(3'd0, LIST_TB[i].data[7:0]);
      end
    end
  endtask

  // peripheral model, acting away from the active edge
  always @(negedge clk) begin
    if (rst_ni) begin
      if (!in_acc && !cs_n && !wr_n) begin
        in_acc  = 1'b1;
        low_cnt = 1;
        rel_cnt = 0;
        if (widx < n_exp) begin
          chk("R3 write address order", int'(a), int'(exp_a[widx]));
          chk("R2 R4 write data", int'(d), int'(exp_d[widx]));
        end else begin
          chk("R8 R10 no extra write", widx, n_exp - 1);
        end
        stuck_now = (widx == stuck_idx);
        lat_cnt   = $urandom_range(0, 20);
        had_low   = stuck_now || (lat_cnt > 0);
        if (had_low) rdy = 1'b0;
      end else if (in_acc && !wr_n) begin
        low_cnt++;
        if (!rdy) begin
          if (!stuck_now) begin
            lat_cnt--;
            if (lat_cnt <= 0) begin
              rdy = 1'b1;
              rel_cnt = 0;
            end
          end
        end else begin
          rel_cnt++;
        end
      end else if (in_acc && wr_n) begin
        in_acc = 1'b0;
        if (stuck_now) begin
          chk("R8 strobe length at timeout", low_cnt, TO_EXP);
        end else begin
          chk("R5 minimum strobe length", int'(low_cnt >= WS_EXP), 1);
          if (had_low) chk("R6 sync delay after ready", int'(rel_cnt >= 2), 1);
          if (widx < n_exp && exp_a[widx] == 3'd3) bench_sh = exp_d[widx];
        end
        rdy = 1'b1;
        widx++;
      end
    end
  end

  task automatic run_seq(input int stuck, input bit poke);
    int cyc;
    stuck_idx = stuck;
    widx = 0;
    build_exp(bench_sh);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R9 start clears err", int'(err), 0);
    chk("R9 start raises busy", int'(busy), 1);
    if (poke) begin
      repeat (40) @(negedge clk);
      chk("R9 still busy before poke", int'(busy), 1);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    chk("R10 busy low at end", int'(busy), 0);
    chk("R10 done high at end", int'(done), 1);
    if (stuck < 0) begin
      chk("R10 write count", widx, n_exp);
      chk("R10 no error", int'(err), 0);
    end else begin
      chk("R8 error flagged", int'(err), 1);
      chk("R8 writes stop at abort", widx, stuck + 1);
    end
    repeat (20) @(negedge clk);
    chk("R10 idle chip select", int'(cs_n), 1);
    chk("R1 read strobe idle", int'(rd_n), 1);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed);
    stuck_idx = -1;
    widx = 0;
    n_exp = 0;
    in_acc = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset cs", int'(cs_n), 1);
    chk("R1 reset wr", int'(wr_n), 1);
    chk("R1 reset rd", int'(rd_n), 1);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset done", int'(done), 0);
    chk("R1 reset err", int'(err), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after reset cs", int'(cs_n), 1);
    chk("R1 after reset busy", int'(busy), 0);

    run_seq(-1, 1'b0);   // R2 R3 R4 baseline
    run_seq(-1, 1'b1);   // R9 start ignored while busy
    run_seq(7, 1'b0);    // R8 timeout on a data-register write
    run_seq(-1, 1'b0);   // R9 clean rerun after error
    run_seq(0, 1'b0);    // R8 timeout on the first write
    for (int k = 0; k < 3; k++) run_seq(-1, 1'b0);

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL R10 watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule